// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Unit

This block evaluates A*B+C on three 16-bit floating-point words and rounds only once, after the sum is formed. The two 11-bit significands are multiplied to full width. C is then shifted against the product's exponent, left when C is the larger of the two and right when it is the smaller. The two are added or subtracted according to the effective sign. A leading-zero count drives the normalizing shift, and a single round-to-nearest-even step produces the 10-bit fraction.

The caller presents A, B and C together with a one-cycle `in_valid` strobe. One clock later the result appears on a registered output with `out_valid` high. Normal numbers and exact zeros are handled. A word whose exponent field is 0 is read as zero. Results outside the normal range become infinity or a signed zero.

Top module: `fma16_unit`

## Requirements
- R1: Each word carries its sign in bit 15, a biased exponent (bias 15) in bits 14:10 and the fraction in bits 9:0, with an implied leading one. An exponent field of 0 means zero. When C is zero and A and B are not, the result is A*B rounded once to nearest-even.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_result` changes only in those cycles and holds its value otherwise.
- R3: C is aligned to the product's exponent whether C is larger (left shift) or smaller (right shift). The result equals the exact sum rounded once.
- R4: When the product and C have opposite signs, the magnitudes are subtracted and the result takes the sign of the larger one. An exact cancellation gives +0 (0x0000).
- R5: Rounding is to nearest with ties to even. Bits of C shifted out below the adder window count as sticky, so a value just below a halfway point rounds down.
- R6: A rounding carry out of the significand clears the fraction and raises the exponent by one.
- R7: A final exponent above 30 gives infinity with the computed sign (0x7C00 or 0xFC00).
- R8: A final exponent below 1 gives a zero with the computed sign (0x0000 or 0x8000). No output has a zero exponent and a nonzero fraction.
- R9: When A or B is zero, the result is C, bit for bit.
- R10: When the product lies more than 13 binades below C, the result is C. At exactly 13 binades the adder path still produces the correctly rounded sum.
- R11: While reset is high, `out_valid` is 0 and `out_result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| in_a | input | 16 | Multiplicand |
| in_b | input | 16 | Multiplier |
| in_c | input | 16 | Addend |
| out_valid | output | 1 | Result is new this cycle |
| out_result | output | 16 | Registered A*B+C |

## Verification
Two pairs of functions can meet in one operation. The first pair is the rounding carry and the overflow to infinity: the largest finite product plus exactly half an ulp ties, rounds up to even, and crosses into exponent 31. The second pair is alignment sticky and the tie decision: C is shifted far enough right that its last bit falls out of the window, and the value then lies just below a halfway point. Both cases are driven as directed operands with hand-derived results. Thousands of random operands, including near-cancelling ones, are compared against an exact wide-integer model in the bench that rounds once to nearest-even.

// File: rtl/fma16_pkg.sv
package fma16_pkg;
  localparam int EXP_W    = 5;
  localparam int FRAC_W   = 10;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int PROD_W   = 2 * SIG_W;
  localparam int LEFT_MAX = FRAC_W + 3;
  localparam int ALN_W    = PROD_W + LEFT_MAX;
  localparam int SUM_W    = ALN_W + 1;
  localparam int LZ_W     = $clog2(SUM_W + 1);
  localparam int SH_W     = $clog2(ALN_W + 1);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX  = (1 << EXP_W) - 2;
  localparam int SE_W     = EXP_W + 3;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_t;
endpackage

// File: rtl/fma16_prep.sv
module fma16_prep
  import fma16_pkg::*;
(
  input  logic [EXP_W-1:0]    a_exp,
  input  logic [FRAC_W-1:0]   a_frac,
  input  logic [EXP_W-1:0]    b_exp,
  input  logic [FRAC_W-1:0]   b_frac,
  input  logic [EXP_W-1:0]    c_exp,
  input  logic [FRAC_W-1:0]   c_frac,
  output logic [PROD_W-1:0]   prod,
  output logic signed [SE_W-1:0] prod_exp,
  output logic [ALN_W-1:0]    c_aln,
  output logic                c_stk,
  output logic                far_c,
  output logic                any_zero
);
  localparam logic signed [SE_W-1:0] LEFT_LIM = SE_W'(-LEFT_MAX);
  localparam logic [SE_W-1:0]        SH_CAP   = SE_W'(ALN_W);

  logic [SIG_W-1:0]       sig_a, sig_b, sig_c;
  logic signed [SE_W-1:0] diff;
  logic [SE_W-1:0]        sh_full;
  logic [SH_W-1:0]        sh;
  logic [2*ALN_W-1:0]     c_ext;

  assign any_zero = (a_exp == '0) || (b_exp == '0);
  assign sig_a    = {1'b1, a_frac};
  assign sig_b    = {1'b1, b_frac};
  assign sig_c    = (c_exp == '0) ? '0 : {1'b1, c_frac};

  // full-width significand product, exponent kept biased
  assign prod     = PROD_W'(sig_a) * PROD_W'(sig_b);
  assign prod_exp = $signed(SE_W'(a_exp)) + $signed(SE_W'(b_exp)) - $signed(SE_W'(BIAS));

  // positive diff: C smaller, shift right; negative: C larger, shift left
  assign diff    = prod_exp - $signed(SE_W'(c_exp));
  assign far_c   = diff < LEFT_LIM;
  assign sh_full = diff + SE_W'(LEFT_MAX);

  always_comb begin
    if (far_c)              sh = '0;
    else if (sh_full > SH_CAP) sh = SH_W'(ALN_W);
    else                    sh = sh_full[SH_W-1:0];
  end

  // C placed at its leftmost slot, then moved right; lower half feeds sticky
  assign c_ext = {sig_c, {(2*ALN_W-SIG_W){1'b0}}} >> sh;
  assign c_aln = c_ext[2*ALN_W-1 -: ALN_W];
  assign c_stk = |c_ext[ALN_W-1:0];
endmodule

// File: rtl/fma16_lzc.sv
module fma16_lzc #(
  parameter int WIDTH = 36,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) count = CNT_W'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/fma16_addnorm.sv
module fma16_addnorm
  import fma16_pkg::*;
(
  input  logic [PROD_W-1:0]      prod,
  input  logic signed [SE_W-1:0] prod_exp,
  input  logic [ALN_W-1:0]       c_aln,
  input  logic                   c_stk,
  input  logic                   prod_sign,
  input  logic                   c_sign,
  output logic [SUM_W-1:0]       norm,
  output logic                   stk,
  output logic                   res_sign,
  output logic signed [SE_W-1:0] res_exp,
  output logic                   is_zero
);
  logic          eff_sub, neg;
  logic [SUM_W:0] p_w, c_w, raw;
  logic [SUM_W-1:0] mag;
  logic [LZ_W-1:0]  lz;

  assign eff_sub = prod_sign ^ c_sign;
  assign p_w     = {{(SUM_W-PROD_W){1'b0}}, prod, 1'b0};
  assign c_w     = {2'b00, c_aln};

  // sticky is taken as a borrow so the kept bits equal floor of the exact value
  assign raw = eff_sub ? (p_w - c_w - (SUM_W+1)'(c_stk)) : (p_w + c_w);
  assign neg = eff_sub & raw[SUM_W];
  assign mag = neg ? (~raw[SUM_W-1:0] + SUM_W'(1)) : raw[SUM_W-1:0];

  fma16_lzc #(.WIDTH(SUM_W), .CNT_W(LZ_W)) u_lzc (.vec(mag), .count(lz));

  assign norm     = mag << lz;
  assign stk      = c_stk;
  assign is_zero  = (mag == '0);
  assign res_sign = neg ? c_sign : prod_sign;
  assign res_exp  = prod_exp + $signed(SE_W'(SUM_W - PROD_W)) - $signed(SE_W'(lz));
endmodule

// File: rtl/fma16_round.sv
module fma16_round
  import fma16_pkg::*;
(
  input  logic [SUM_W-1:0]       norm,
  input  logic                   stk,
  input  logic                   sign,
  input  logic signed [SE_W-1:0] exp_in,
  input  logic                   is_zero,
  output fp_t                    result
);
  localparam logic signed [SE_W-1:0] EXP_TOP = SE_W'(EXP_MAX);
  localparam logic signed [SE_W-1:0] EXP_BOT = SE_W'(1);

  logic [SIG_W-1:0]       keep;
  logic                   g_bit, r_bit, s_bit, up, carry;
  logic [SIG_W:0]         rounded;
  logic signed [SE_W-1:0] exp_f;

  assign keep  = norm[SUM_W-1 -: SIG_W];
  assign g_bit = norm[SUM_W-1-SIG_W];
  assign r_bit = norm[SUM_W-2-SIG_W];
  assign s_bit = (|norm[SUM_W-3-SIG_W:0]) | stk;

  assign up      = g_bit & (r_bit | s_bit | keep[0]);
  assign rounded = {1'b0, keep} + (SIG_W+1)'(up);
  assign carry   = rounded[SIG_W];
  assign exp_f   = exp_in + $signed(SE_W'(carry));

  always_comb begin
    result.sign = sign;
    result.exp  = exp_f[EXP_W-1:0];
    result.frac = carry ? '0 : rounded[FRAC_W-1:0];
    if (is_zero) begin
      result = '0;
    end else if (exp_f > EXP_TOP) begin
      result.exp  = '1;
      result.frac = '0;
    end else if (exp_f < EXP_BOT) begin
      result.exp  = '0;
      result.frac = '0;
    end
  end
endmodule

// File: rtl/fma16_unit.sv
module fma16_unit
  import fma16_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_a,
  input  logic [15:0] in_b,
  input  logic [15:0] in_c,
  output logic        out_valid,
  output logic [15:0] out_result
);
  fp_t a_f, b_f, c_f, rnd_f;
  logic [PROD_W-1:0]      prod;
  logic signed [SE_W-1:0] prod_exp, res_exp;
  logic [ALN_W-1:0]       c_aln;
  logic                   c_stk, far_c, any_zero;
  logic [SUM_W-1:0]       norm;
  logic                   stk, res_sign, is_zero;
  logic [WORD_W-1:0]      next_res;

  assign a_f = in_a;
  assign b_f = in_b;
  assign c_f = in_c;

  fma16_prep u_prep (
    .a_exp(a_f.exp), .a_frac(a_f.frac),
    .b_exp(b_f.exp), .b_frac(b_f.frac),
    .c_exp(c_f.exp), .c_frac(c_f.frac),
    .prod(prod), .prod_exp(prod_exp),
    .c_aln(c_aln), .c_stk(c_stk),
    .far_c(far_c), .any_zero(any_zero)
  );

  fma16_addnorm u_addnorm (
    .prod(prod), .prod_exp(prod_exp),
    .c_aln(c_aln), .c_stk(c_stk),
    .prod_sign(a_f.sign ^ b_f.sign), .c_sign(c_f.sign),
    .norm(norm), .stk(stk), .res_sign(res_sign),
    .res_exp(res_exp), .is_zero(is_zero)
  );

  fma16_round u_round (
    .norm(norm), .stk(stk), .sign(res_sign),
    .exp_in(res_exp), .is_zero(is_zero), .result(rnd_f)
  );

  assign next_res = (any_zero || far_c) ? in_c : rnd_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_res;
    end
  end
endmodule

// File: rtl/fma16_unit_chk.sv
module fma16_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [15:0] in_a,
  input logic [15:0] in_b,
  input logic [15:0] in_c,
  input logic        out_valid,
  input logic [15:0] out_result
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

  // R9
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_a[14:10] == 5'd0 || in_b[14:10] == 5'd0)) |=> (out_result == $past(in_c)));

  // R8
  no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_result[14:10] != 5'd0 || out_result[9:0] == 10'd0));

  // R7
  inf_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result[14:10] == 5'h1F) |-> (out_result[9:0] == 10'd0));
endmodule

bind fma16_unit fma16_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .in_a(in_a), .in_b(in_b), .in_c(in_c),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/tb_fma16_unit.sv
module tb_fma16_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0, in_b = '0, in_c = '0;
  logic        out_valid;
  logic [15:0] out_result;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        started = 1'b0;
  logic        vin_d = 1'b0;
  logic        have_last = 1'b0;
  logic [15:0] last_res = '0;

  always #5 clk = ~clk;

  fma16_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // exact model: values scaled by 2^60 in a wide integer, rounded once
  function automatic logic [15:0] ref_fma(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    logic [127:0] pm, cm, mag, m, rem, half;
    logic signed [127:0] sv;
    logic s;
    int p, e, sh;
    if (a[14:10] == 5'd0 || b[14:10] == 5'd0) return c;
    pm = 128'({1'b1, a[9:0]}) * 128'({1'b1, b[9:0]});
    pm = pm << (int'(a[14:10]) + int'(b[14:10]) + 10);
    cm = (c[14:10] == 5'd0) ? 128'd0 : (128'({1'b1, c[9:0]}) << (int'(c[14:10]) + 35));
    sv = ((a[15] ^ b[15]) ? -$signed(pm) : $signed(pm)) + (c[15] ? -$signed(cm) : $signed(cm));
    if (sv == 0) return 16'h0000;
    s = sv < 0;
    mag = s ? 128'(-sv) : 128'(sv);
    p = 0;
    for (int i = 0; i < 128; i++) if (mag[i]) p = i;
    e = p - 45;
    sh = p - 10;
    m = mag >> sh;
    rem = mag - (m << sh);
    half = 128'd1 << (sh - 1);
    if (rem > half || (rem == half && m[0])) m = m + 1;
    if (m == 128'd2048) begin
      m = 128'd1024;
      e = e + 1;
    end
    if (e > 30) return {s, 5'h1F, 10'd0};
    if (e < 1) return {s, 15'd0};
    return {s, 5'(e), m[9:0]};
  endfunction

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                      input logic [15:0] want, input string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_c = c; in_valid = 1'b1;
    exp_q.push_back(want);
    tag_q.push_back(tag);
  endtask

  task automatic send_ref(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input string tag);
    send(a, b, c, ref_fma(a, b, c), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_a = $urandom(); in_b = $urandom(); in_c = $urandom();
  endtask

  function automatic logic [15:0] rnd_op();
    logic [15:0] v;
    if ($urandom_range(0, 15) == 0) return {1'($urandom_range(0, 1)), 15'd0};
    v[15]    = 1'($urandom_range(0, 1));
    v[14:10] = 5'($urandom_range(1, 30));
    v[9:0]   = 10'($urandom());
    return v;
  endfunction

  always @(posedge clk) vin_d <= in_valid;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (started) begin
      check(out_valid == vin_d, "R2 valid timing", {15'd0, out_valid}, {15'd0, vin_d});
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", out_result, 16'hxxxx);
        end else begin
          logic [15:0] w;
          string t;
          w = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_result == w, t, out_result, w);
        end
        last_res  = out_result;
        have_last = 1'b1;
      end else if (have_last) begin
        check(out_result == last_res, "R2 hold", out_result, last_res);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11 reset valid", {15'd0, out_valid}, 16'h0000);
    check(out_result == 16'h0000, "R11 reset result", out_result, 16'h0000);
    rst = 1'b0;
    started = 1'b1;

    send(16'h3C00, 16'h3C00, 16'h0000, 16'h3C00, "R1 one times one");
    send(16'h4000, 16'h3E00, 16'h0000, 16'h4200, "R1 two times 1.5");
    send(16'h3C00, 16'h3C00, 16'h8000, 16'h3C00, "R1 minus-zero addend");
    send(16'h4000, 16'h3E00, 16'h3C00, 16'h4400, "R3 left align");
    send(16'h3C00, 16'h3C00, 16'h3400, 16'h3D00, "R3 right align");
    send(16'h3C00, 16'h3C00, 16'hC000, 16'hBC00, "R4 larger negative");
    send(16'h3C00, 16'h3C00, 16'hBC00, 16'h0000, "R4 cancellation");
    idle();
    send(16'hBC00, 16'h3C00, 16'h3C00, 16'h0000, "R4 cancellation negative product");
    send(16'h3C00, 16'h3C00, 16'h1000, 16'h3C00, "R5 tie to even down");
    send(16'h3C00, 16'h3C00, 16'h8C01, 16'h3BFF, "R5 sticky below half");
    send(16'h3FFF, 16'h3C00, 16'h1000, 16'h4000, "R6 rounding carry");
    send(16'h7BFF, 16'h7BFF, 16'h0000, 16'h7C00, "R7 overflow positive");
    send(16'hFBFF, 16'h7BFF, 16'h0000, 16'hFC00, "R7 overflow negative");
    send(16'h7BFF, 16'h3C00, 16'h4C00, 16'h7C00, "R6 R7 carry into overflow");
    idle();
    idle();
    send(16'h0400, 16'h0400, 16'h0000, 16'h0000, "R8 underflow positive");
    send(16'h8400, 16'h0400, 16'h0000, 16'h8000, "R8 underflow negative");
    send(16'h0000, 16'h4567, 16'hC123, 16'hC123, "R9 zero A");
    send(16'h3C00, 16'h8000, 16'h4321, 16'h4321, "R9 zero B");
    send(16'h3C00, 16'h3C00, 16'h7400, 16'h7400, "R10 far C");
    send(16'h3C00, 16'h3C00, 16'h7000, 16'h7000, "R10 edge C");
    send_ref(16'h3C00, 16'h3C00, 16'hF000, "R10 edge C negative");

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a, b, c;
      a = rnd_op();
      b = rnd_op();
      if (k % 4 == 0) begin
        c = ref_fma(a, b, 16'h0000) ^ 16'h8000;
        if (c[14:10] == 5'h1F) c = rnd_op();
        send_ref(a, b, c, "R4 near cancellation");
      end else begin
        c = rnd_op();
        send_ref(a, b, c, "R1 R3 R5 random");
      end
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule